// File: doc/BRIEF.md
# Presettable Synchronous Binary Counter

This block is a fully synchronous binary up-counter. The default width is four bits. The clock's rising edge changes the stored value, and only then. On each edge the counter does one of four things: it clears to zero, it takes a parallel data word, it advances by one, or it keeps its value. Two active-low controls select clearing and parallel loading. Clear wins over load, and load wins over counting. Counting also needs two separate enables to be high together: a parallel enable and a trickle enable.

A combinational carry output is high when the count is at its maximum and the trickle enable is high. The parallel enable has no effect on the carry. To build a wider counter, tie every stage's clock and parallel enable together and drive each stage's trickle enable from the carry of the stage below. To get a shorter count length, decode the outputs at the wanted last value and feed that decode back into the synchronous clear. An asynchronous active-low reset is synchronised inside the block before use. Before software trusts a count, it should issue either this reset or a synchronous clear.

Top module: `presettable_counter`

## Requirements
- R1: When clear_ni is low at a rising edge, the count is 0 after that edge, whatever the load and enable inputs are.
- R2: When clear_ni is high and load_ni is low at a rising edge, the count equals data_i after that edge. Any value from 0 to 2^WIDTH-1 can be loaded, and the enables have no effect.
- R3: When clear_ni, load_ni, en_par_i and en_trk_i are all high at a rising edge, the count increases by one. It wraps from 2^WIDTH-1 (15 by default) to 0.
- R4: When clear_ni and load_ni are both high and either enable is low at a rising edge, the count keeps its value.
- R5: carry_o is high only when the count is 2^WIDTH-1 and en_trk_i is high. It follows en_trk_i without waiting for a clock edge and does not depend on en_par_i.
- R6: Pulses on the control inputs between rising edges leave the count unchanged. Only the values present at the edge decide the operation.
- R7: While rst_ni is low the count is 0 and carry_o is low. The reset is released through a synchroniser, so the counter holds 0 for SYNC_STAGES edges after rst_ni rises.
- R8: Two stages can be cascaded by sharing the clock and parallel enable and driving the upper stage's trickle enable from the lower stage's carry. The pair then counts as one binary counter of twice the width, wrapping at 2^(2*WIDTH).
- R9: Feeding a decode of count value M back into clear_ni makes the counter cycle through 0 to M, a modulus of M+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; every state change happens on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| clear_ni | input | 1 | Synchronous clear, active low, highest priority |
| load_ni | input | 1 | Synchronous parallel load, active low |
| data_i | input | WIDTH | Value taken on a load |
| en_par_i | input | 1 | Parallel count enable |
| en_trk_i | input | 1 | Trickle count enable, also gates carry_o |
| count_o | output | WIDTH | Current count |
| carry_o | output | 1 | Ripple carry: count at maximum and en_trk_i high |

## Verification
A wrong next-state choice shows up on count_o at the first edge after the stimulus. Examples are load winning over clear, or the counter advancing with only one enable high. The bench therefore compares the count one edge after every operation. A fault in the carry gating is only visible when the count sits at its maximum, so the enables are toggled at that value and the carry is compared with no clock edge in between. Errors that build up slowly, such as a lost wrap or a broken cascade link, show up within one full pass through the count range. That is why the cascade and modulus scenarios run for more than one complete wrap.

// File: rtl/presettable_counter_pkg.sv
package presettable_counter_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } ctr_op_e;
endpackage

// File: rtl/ctr_rst_sync.sv
module ctr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/ctr_op_decode.sv
module ctr_op_decode
  import presettable_counter_pkg::*;
(
  input  logic    clear_ni,
  input  logic    load_ni,
  input  logic    en_par_i,
  input  logic    en_trk_i,
  output ctr_op_e op_o
);
  // Fixed priority: clear, then load, then count (both enables), else hold.
  always_comb begin
    if (!clear_ni) begin
      op_o = OP_CLEAR;
    end else if (!load_ni) begin
      op_o = OP_LOAD;
    end else if (en_par_i && en_trk_i) begin
      op_o = OP_COUNT;
    end else begin
      op_o = OP_HOLD;
    end
  end
endmodule

// File: rtl/ctr_next_value.sv
module ctr_next_value
  import presettable_counter_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  ctr_op_e          op_i,
  input  logic [WIDTH-1:0] cur_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] nxt_o,
  output logic             upd_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_comb begin
    unique case (op_i)
      OP_CLEAR: nxt_o = '0;
      OP_LOAD:  nxt_o = data_i;
      OP_COUNT: nxt_o = cur_i + ONE;
      default:  nxt_o = cur_i;
    endcase
    upd_o = (op_i != OP_HOLD);
  end
endmodule

// File: rtl/ctr_carry_detect.sv
module ctr_carry_detect #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur_i,
  input  logic             en_trk_i,
  output logic             carry_o
);
  localparam logic [WIDTH-1:0] TERMINAL = {WIDTH{1'b1}};

  assign carry_o = en_trk_i && (cur_i == TERMINAL);
endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
  import presettable_counter_pkg::*;
#(
  parameter int unsigned WIDTH       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_ni,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             en_par_i,
  input  logic             en_trk_i,
  output logic [WIDTH-1:0] count_o,
  output logic             carry_o
);
  logic             rst_int_n;
  ctr_op_e          op;
  logic [WIDTH-1:0] count_q;
  logic [WIDTH-1:0] count_d;
  logic             count_en;

  ctr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_int_n)
  );

  ctr_op_decode u_decode (
    .clear_ni (clear_ni),
    .load_ni  (load_ni),
    .en_par_i (en_par_i),
    .en_trk_i (en_trk_i),
    .op_o     (op)
  );

  ctr_next_value #(.WIDTH(WIDTH)) u_next (
    .op_i   (op),
    .cur_i  (count_q),
    .data_i (data_i),
    .nxt_o  (count_d),
    .upd_o  (count_en)
  );

  always_ff @(posedge clk_i or negedge rst_int_n) begin
    if (!rst_int_n) begin
      count_q <= '0;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end

  ctr_carry_detect #(.WIDTH(WIDTH)) u_carry (
    .cur_i    (count_q),
    .en_trk_i (en_trk_i),
    .carry_o  (carry_o)
  );

  assign count_o = count_q;
endmodule

// File: rtl/presettable_counter_chk.sv
module presettable_counter_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_int_n,
  input logic             clear_ni,
  input logic             load_ni,
  input logic [WIDTH-1:0] data_i,
  input logic             en_par_i,
  input logic             en_trk_i,
  input logic [WIDTH-1:0] count_o,
  input logic             carry_o
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  assert_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    !clear_ni |=> count_o == '0);

  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (clear_ni && !load_ni) |=> count_o == $past(data_i));

  assert_count_R3: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (clear_ni && load_ni && en_par_i && en_trk_i) |=>
      count_o == WIDTH'($past(count_o) + WIDTH'(1)));

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (clear_ni && load_ni && !(en_par_i && en_trk_i)) |=> $stable(count_o));

  assert_carry_R5: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    carry_o |-> (en_trk_i && count_o == TOP));

  assert_reset_R7: assert property (@(posedge clk_i)
    !rst_int_n |-> (count_o == '0 && !carry_o));
endmodule

bind presettable_counter presettable_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i     (clk_i),
  .rst_int_n (rst_int_n),
  .clear_ni  (clear_ni),
  .load_ni   (load_ni),
  .data_i    (data_i),
  .en_par_i  (en_par_i),
  .en_trk_i  (en_trk_i),
  .count_o   (count_o),
  .carry_o   (carry_o)
);

// File: tb/presettable_counter_tb_top.sv
`timescale 1ns/1ps
module presettable_counter_tb_top;
  localparam int W = 4;
  localparam int MODV = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // main instance
  logic         clr_n = 1'b1, ld_n = 1'b1, ep = 1'b0, et = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] q;
  logic         rco;

  presettable_counter #(.WIDTH(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clear_ni(clr_n), .load_ni(ld_n),
    .data_i(din), .en_par_i(ep), .en_trk_i(et), .count_o(q), .carry_o(rco));

  // cascade pair
  logic         c_clr_n = 1'b1, c_ep = 1'b0;
  logic [W-1:0] lo_q, hi_q;
  logic         lo_rco, hi_rco;

  presettable_counter #(.WIDTH(W)) lo_i (
    .clk_i(clk), .rst_ni(rst_n), .clear_ni(c_clr_n), .load_ni(1'b1),
    .data_i('0), .en_par_i(c_ep), .en_trk_i(1'b1), .count_o(lo_q), .carry_o(lo_rco));
  presettable_counter #(.WIDTH(W)) hi_i (
    .clk_i(clk), .rst_ni(rst_n), .clear_ni(c_clr_n), .load_ni(1'b1),
    .data_i('0), .en_par_i(c_ep), .en_trk_i(lo_rco), .count_o(hi_q), .carry_o(hi_rco));

  // shortened modulus instance
  logic         m_clr_n = 1'b1, m_ep = 1'b0;
  logic [W-1:0] m_q;
  logic         m_rco;
  logic         m_fb_n;
  assign m_fb_n = m_clr_n && (m_q != W'(MODV));

  presettable_counter #(.WIDTH(W)) mod_i (
    .clk_i(clk), .rst_ni(rst_n), .clear_ni(m_fb_n), .load_ni(1'b1),
    .data_i('0), .en_par_i(m_ep), .en_trk_i(1'b1), .count_o(m_q), .carry_o(m_rco));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // advance to just after the next rising edge
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic load_val(input int v);
    clr_n = 1'b1; ld_n = 1'b0; din = W'(v);
    tick();
    ld_n = 1'b1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    #1;
    chk("R7 count in reset", int'(q), 0);
    chk("R7 carry in reset", int'(rco), 0);
    repeat (2) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    chk("R7 count after release", int'(q), 0);
  endtask

  task automatic t_clear();
    load_val(11);
    clr_n = 1'b0; ld_n = 1'b0; din = W'(6); ep = 1'b1; et = 1'b1;
    #0.5;
    chk("R6 no change before edge", int'(q), 11);
    tick();
    chk("R1 clear beats load and count", int'(q), 0);
    clr_n = 1'b1; ld_n = 1'b1; ep = 1'b0; et = 1'b0;
  endtask

  task automatic t_load();
    load_val(9);
    chk("R2 load 9", int'(q), 9);
    load_val(0);
    chk("R2 load 0", int'(q), 0);
    ep = 1'b1; et = 1'b1;
    load_val(15);
    chk("R2 load 15 over count", int'(q), 15);
    ep = 1'b0; et = 1'b0;
  endtask

  task automatic t_count_carry();
    load_val(13);
    ep = 1'b1; et = 1'b1;
    tick();
    chk("R3 count 13->14", int'(q), 14);
    tick();
    chk("R3 count 14->15", int'(q), 15);
    chk("R5 carry at 15", int'(rco), 1);
    ep = 1'b0;
    #0.5;
    chk("R5 carry ignores en_par", int'(rco), 1);
    et = 1'b0;
    #0.5;
    chk("R5 carry gated by en_trk", int'(rco), 0);
    ep = 1'b1; et = 1'b1;
    tick();
    chk("R3 wrap 15->0", int'(q), 0);
    chk("R5 carry low at 0", int'(rco), 0);
    ep = 1'b0; et = 1'b0;
  endtask

  task automatic t_hold();
    load_val(5);
    ep = 1'b0; et = 1'b1;
    tick();
    chk("R4 hold en_par low", int'(q), 5);
    ep = 1'b1; et = 1'b0;
    tick();
    chk("R4 hold en_trk low", int'(q), 5);
    ep = 1'b0;
  endtask

  task automatic t_midcycle();
    load_val(7);
    #0.3; clr_n = 1'b0; #0.4; clr_n = 1'b1;
    #0.3; ld_n = 1'b0; din = W'(2); #0.4; ld_n = 1'b1;
    ep = 1'b1; et = 1'b1; #0.3; ep = 1'b0; et = 1'b0;
    chk("R6 pulses between edges", int'(q), 7);
    tick();
    chk("R6 idle controls at edge", int'(q), 7);
  endtask

  task automatic t_cascade();
    c_clr_n = 1'b0;
    tick();
    c_clr_n = 1'b1;
    chk("R8 cascade cleared", int'({hi_q, lo_q}), 0);
    c_ep = 1'b1;
    for (int i = 1; i <= 300; i++) begin
      tick();
      chk("R8 cascade value", int'({hi_q, lo_q}), i % 256);
      if (i % 256 == 255) chk("R8 upper carry at max", int'(hi_rco), 1);
    end
    c_ep = 1'b0;
  endtask

  task automatic t_modulus();
    m_clr_n = 1'b0;
    tick();
    m_clr_n = 1'b1;
    m_ep = 1'b1;
    for (int i = 1; i <= 25; i++) begin
      tick();
      chk("R9 modulus value", int'(m_q), i % (MODV + 1));
    end
    m_ep = 1'b0;
  endtask

  initial begin
    #1;
    t_reset();
    t_clear();
    t_load();
    t_count_carry();
    t_hold();
    t_midcycle();
    t_cascade();
    t_modulus();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule